// File: doc/BRIEF.md
# Parallel Bus Initiator Phase Sequencer

This block is the initiator-side controller for an 8-bit parallel peripheral bus. When the host asks for a command, the block waits for the bus to go free and then arbitrates for it. Arbitration uses fixed priority by device ID. If it wins, it selects the chosen target. After that it follows the transfer phases that the target announces. In the command phase it sends command bytes from a small local buffer. In the data phases it moves bytes in or out. It captures the status byte and acts on the messages it receives. When the command completes, it hands the bus back as free.

The target drives a 3-bit phase code and a one-cycle request strobe. The block answers each accepted byte with a one-cycle acknowledge on the following cycle. The target may pause the command with a disconnect message. The command then continues only when that same target reselects the block. A phase that is illegal for the current progress sends the block to a sticky error state. A bus reset clears that state.

Top module: `scsi_phase_seq`

## Requirements
- R1: After power-on reset, or in the cycle after `bus_rst_i` is sampled high, the block drives nothing. `bsy_o`, `sel_o`, `data_oe_o`, `err_o` and `disc_o` are all low.
- R2: A `start_i` pulse, sampled while idle, is remembered. Once both `bus_bsy_i` and `bus_sel_i` are low, the block arbitrates for one cycle. During that cycle it raises `bsy_o` and drives only its own ID bit (default ID 6, value 0x40). A start that names the block's own ID is ignored.
- R3: The block loses arbitration when the ID bus shows any ID bit numerically above its own, or when `bus_sel_i` is high. On a loss it releases the bus, never raises `sel_o`, and retries at the next bus-free cycle. Lower-numbered ID bits do not affect the outcome.
- R4: After a win, the block raises `sel_o` and drops `bsy_o`. It drives its own ID bit together with the target's ID bit. It stays in selection until `bus_bsy_i` goes high, and then releases `sel_o`.
- R5: Each request in the command phase (phase code 2) is answered in the next cycle by `ack_o` with `data_oe_o`. The data carries the next buffer byte, starting at address 0 and continuing for `cmd_len_i` bytes. A command request after the last byte sends the block to error.
- R6: For a data-in request (code 1), the block presents `data_i` on `rx_data_o` with `rx_valid_o` in the next cycle. For a data-out request (code 0), it drives `dout_i` with `ack_o` and pulses `tx_take_o`. A data phase that comes before the command bytes are finished sends the block to error.
- R7: A status request (code 3) stores the byte. A message-in request (code 7) with byte 0x00, arriving after a status byte, pulses `done_o` for one cycle with the stored status on `status_o` and returns the block to the idle, undriven bus. The same byte 0x00 with no status byte seen sends the block to error.
- R8: Message-in bytes 0x02 and 0x03, and any byte with bit 7 set, are acknowledged and have no other effect. A message-out request (code 6) is answered with byte 0xC0. Any other message-in byte sends the block to error.
- R9: Message-in byte 0x04 releases the bus and raises `disc_o`. While disconnected, `start_i` is ignored. Reselection is recognised only when `bus_sel_i` is high and the ID bus equals exactly the own bit OR the original target bit. The block then raises `bsy_o`. When `bus_sel_i` drops, it resumes transfers with the command's progress intact.
- R10: The reserved phase codes 4 and 5 send the block to error. In error, `err_o` is high, nothing is driven or acknowledged, and `start_i` is ignored. Only `bus_rst_i` leaves the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_rst_i | input | 1 | Bus reset, synchronous, highest priority |
| start_i | input | 1 | Begin one command |
| tgt_id_i | input | 3 | Target ID for the command |
| cmd_len_i | input | 5 | Number of command bytes |
| cbuf_we_i | input | 1 | Command buffer write enable |
| cbuf_addr_i | input | 4 | Command buffer write address |
| cbuf_data_i | input | 8 | Command buffer write data |
| bus_bsy_i | input | 1 | Busy line as driven by other devices |
| bus_sel_i | input | 1 | Select line as driven by other devices |
| id_bus_i | input | 8 | Data/ID lines as seen on the bus |
| req_i | input | 1 | One-cycle byte request from the target |
| phase_i | input | 3 | Phase code from the target |
| data_i | input | 8 | Byte from the target |
| dout_i | input | 8 | Host byte for data-out |
| tx_take_o | output | 1 | Host byte consumed |
| bsy_o | output | 1 | Busy drive |
| sel_o | output | 1 | Select drive |
| data_o | output | 8 | Data/ID drive value |
| data_oe_o | output | 1 | Data/ID drive enable |
| ack_o | output | 1 | Byte acknowledge |
| rx_valid_o | output | 1 | Received data byte valid |
| rx_data_o | output | 8 | Received data byte |
| done_o | output | 1 | Command complete pulse |
| status_o | output | 8 | Status byte of the command |
| disc_o | output | 1 | Disconnected, awaiting reselection |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench goes after the arbitration boundary: a lower-numbered competitor must not block the block, while a higher-numbered one must keep `sel_o` low through repeated retries. A wrong comparison would either deadlock or select against a winner. It walks a disconnect with a stray start and a reselection by the wrong target. A design that accepted either would raise `bsy_o` or lose the command's progress, and the following status phase would then be flagged. It also drives the ordering traps: a command byte past the length, data before the command, completion without status, and reserved phases. A lax design would acknowledge these where the error state is required.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
  typedef enum logic [2:0] {
    PH_DOUT = 3'd0, PH_DIN = 3'd1, PH_CMD = 3'd2, PH_STAT = 3'd3,
    PH_RSV4 = 3'd4, PH_RSV5 = 3'd5, PH_MOUT = 3'd6, PH_MIN = 3'd7
  } phase_e;

  typedef enum logic [2:0] {
    S_FREE, S_ARB, S_SEL, S_XFER, S_DISC, S_RESEL, S_ERR
  } state_e;

  typedef enum logic [2:0] {
    M_COMPLETE, M_DISCON, M_SAVE, M_RESTORE, M_IDENT, M_BAD
  } msg_e;

  localparam logic [7:0] MSG_COMPLETE = 8'h00;
  localparam logic [7:0] MSG_SAVE     = 8'h02;
  localparam logic [7:0] MSG_RESTORE  = 8'h03;
  localparam logic [7:0] MSG_DISCON   = 8'h04;
  localparam logic [7:0] MSG_OUT_ID   = 8'hC0;
endpackage

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
  parameter int ID_W   = 3,
  parameter int OWN_ID = 6,
  localparam int BW    = 1 << ID_W
) (
  input  logic [BW-1:0] id_bus_i,
  output logic          win_o
);
  logic [BW-1:0] above_mask;

  for (genvar i = 0; i < BW; i++) begin : g_mask
    if (i > OWN_ID) begin : g_hi
      assign above_mask[i] = 1'b1;
    end else begin : g_lo
      assign above_mask[i] = 1'b0;
    end
  end

  assign win_o = ~|(id_bus_i & above_mask);
endmodule

// File: rtl/scsi_cmd_buf.sv
module scsi_cmd_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/scsi_msg_dec.sv
module scsi_msg_dec
  import scsi_seq_pkg::*;
(
  input  logic [7:0] byte_i,
  output msg_e       kind_o
);
  always_comb begin
    if (byte_i[7])                   kind_o = M_IDENT;
    else if (byte_i == MSG_COMPLETE) kind_o = M_COMPLETE;
    else if (byte_i == MSG_DISCON)   kind_o = M_DISCON;
    else if (byte_i == MSG_SAVE)     kind_o = M_SAVE;
    else if (byte_i == MSG_RESTORE)  kind_o = M_RESTORE;
    else                             kind_o = M_BAD;
  end
endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
  import scsi_seq_pkg::*;
#(
  parameter int ID_W      = 3,
  parameter int OWN_ID    = 6,
  parameter int CMD_DEPTH = 16,
  localparam int BW       = 1 << ID_W,
  localparam int CAW      = $clog2(CMD_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_rst_i,
  input  logic           start_i,
  input  logic [ID_W-1:0] tgt_id_i,
  input  logic [CAW:0]   cmd_len_i,
  input  logic           cbuf_we_i,
  input  logic [CAW-1:0] cbuf_addr_i,
  input  logic [BW-1:0]  cbuf_data_i,
  input  logic           bus_bsy_i,
  input  logic           bus_sel_i,
  input  logic [BW-1:0]  id_bus_i,
  input  logic           req_i,
  input  logic [2:0]     phase_i,
  input  logic [BW-1:0]  data_i,
  input  logic [BW-1:0]  dout_i,
  output logic           tx_take_o,
  output logic           bsy_o,
  output logic           sel_o,
  output logic [BW-1:0]  data_o,
  output logic           data_oe_o,
  output logic           ack_o,
  output logic           rx_valid_o,
  output logic [BW-1:0]  rx_data_o,
  output logic           done_o,
  output logic [BW-1:0]  status_o,
  output logic           disc_o,
  output logic           err_o
);
  localparam logic [BW-1:0]   ONE_BIT = {{(BW-1){1'b0}}, 1'b1};
  localparam logic [BW-1:0]   OWN_BIT = ONE_BIT << OWN_ID;
  localparam logic [ID_W-1:0] OWN_IDX = ID_W'(OWN_ID);
  localparam logic [CAW:0]    IDX_ONE = {{CAW{1'b0}}, 1'b1};

  state_e         state_q;
  logic           pend_q, cmd_done_q, stat_seen_q;
  logic [ID_W-1:0] tgt_q;
  logic [CAW:0]   len_q, idx_q, idx_nxt;
  logic [BW-1:0]  dq_q, rxd_q, status_q;
  logic           ack_q, doe_q, rxv_q, done_q, take_q;
  logic [BW-1:0]  cbuf_rd, tgt_bit;
  logic           win, bus_free;
  msg_e           msg_kind;

  scsi_arb_prio #(.ID_W(ID_W), .OWN_ID(OWN_ID)) u_arb (
    .id_bus_i (id_bus_i),
    .win_o    (win)
  );

  scsi_cmd_buf #(.DEPTH(CMD_DEPTH), .DW(BW)) u_cbuf (
    .clk_i   (clk_i),
    .we_i    (cbuf_we_i),
    .waddr_i (cbuf_addr_i),
    .wdata_i (cbuf_data_i),
    .raddr_i (idx_q[CAW-1:0]),
    .rdata_o (cbuf_rd)
  );

  scsi_msg_dec u_mdec (
    .byte_i (data_i),
    .kind_o (msg_kind)
  );

  assign tgt_bit  = ONE_BIT << tgt_q;
  assign bus_free = !bus_bsy_i && !bus_sel_i;
  assign idx_nxt  = idx_q + IDX_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_FREE;
      pend_q      <= 1'b0;
      cmd_done_q  <= 1'b0;
      stat_seen_q <= 1'b0;
      tgt_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      dq_q        <= '0;
      rxd_q       <= '0;
      status_q    <= '0;
      ack_q       <= 1'b0;
      doe_q       <= 1'b0;
      rxv_q       <= 1'b0;
      done_q      <= 1'b0;
      take_q      <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      doe_q  <= 1'b0;
      rxv_q  <= 1'b0;
      done_q <= 1'b0;
      take_q <= 1'b0;
      if (bus_rst_i) begin
        state_q     <= S_FREE;
        pend_q      <= 1'b0;
        cmd_done_q  <= 1'b0;
        stat_seen_q <= 1'b0;
        idx_q       <= '0;
      end else begin
        unique case (state_q)
          S_FREE: begin
            if (start_i && !pend_q && tgt_id_i != OWN_IDX) begin
              pend_q      <= 1'b1;
              tgt_q       <= tgt_id_i;
              len_q       <= cmd_len_i;
              idx_q       <= '0;
              cmd_done_q  <= (cmd_len_i == '0);
              stat_seen_q <= 1'b0;
            end
            if (pend_q && bus_free) state_q <= S_ARB;
          end
          S_ARB: begin
            if (win && !bus_sel_i) begin
              state_q <= S_SEL;
              pend_q  <= 1'b0;
            end else begin
              state_q <= S_FREE;
            end
          end
          S_SEL: begin
            if (bus_bsy_i) state_q <= S_XFER;
          end
          S_XFER: begin
            if (req_i) begin
              unique case (phase_e'(phase_i))
                PH_CMD: begin
                  if (cmd_done_q) state_q <= S_ERR;
                  else begin
                    ack_q <= 1'b1;
                    doe_q <= 1'b1;
                    dq_q  <= cbuf_rd;
                    idx_q <= idx_nxt;
                    if (idx_nxt == len_q) cmd_done_q <= 1'b1;
                  end
                end
                PH_DOUT: begin
                  if (!cmd_done_q) state_q <= S_ERR;
                  else begin
                    ack_q  <= 1'b1;
                    doe_q  <= 1'b1;
                    dq_q   <= dout_i;
                    take_q <= 1'b1;
                  end
                end
                PH_DIN: begin
                  if (!cmd_done_q) state_q <= S_ERR;
                  else begin
                    ack_q <= 1'b1;
                    rxv_q <= 1'b1;
                    rxd_q <= data_i;
                  end
                end
                PH_STAT: begin
                  if (!cmd_done_q) state_q <= S_ERR;
                  else begin
                    ack_q       <= 1'b1;
                    status_q    <= data_i;
                    stat_seen_q <= 1'b1;
                  end
                end
                PH_MOUT: begin
                  ack_q <= 1'b1;
                  doe_q <= 1'b1;
                  dq_q  <= MSG_OUT_ID;
                end
                PH_MIN: begin
                  unique case (msg_kind)
                    M_COMPLETE: begin
                      if (stat_seen_q) begin
                        ack_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= S_FREE;
                      end else begin
                        state_q <= S_ERR;
                      end
                    end
                    M_DISCON: begin
                      ack_q   <= 1'b1;
                      state_q <= S_DISC;
                    end
                    M_SAVE, M_RESTORE, M_IDENT: ack_q <= 1'b1;
                    default: state_q <= S_ERR;
                  endcase
                end
                default: state_q <= S_ERR;
              endcase
            end
          end
          S_DISC: begin
            if (bus_sel_i && id_bus_i == (OWN_BIT | tgt_bit)) state_q <= S_RESEL;
          end
          S_RESEL: begin
            if (!bus_sel_i) state_q <= S_XFER;
          end
          default: state_q <= S_ERR;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      S_ARB:   data_o = OWN_BIT;
      S_SEL:   data_o = OWN_BIT | tgt_bit;
      default: data_o = doe_q ? dq_q : '0;
    endcase
  end

  assign bsy_o      = (state_q == S_ARB) || (state_q == S_RESEL);
  assign sel_o      = (state_q == S_SEL);
  assign data_oe_o  = (state_q == S_ARB) || (state_q == S_SEL) || doe_q;
  assign ack_o      = ack_q;
  assign tx_take_o  = take_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign disc_o     = (state_q == S_DISC);
  assign err_o      = (state_q == S_ERR);
endmodule

// File: rtl/scsi_phase_seq_chk.sv
module scsi_phase_seq_chk #(
  parameter int BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_rst_i,
  input logic          req_i,
  input logic          bsy_o,
  input logic          sel_o,
  input logic [BW-1:0] data_o,
  input logic          data_oe_o,
  input logic          ack_o,
  input logic          done_o,
  input logic          disc_o,
  input logic          err_o
);
  a_r1_bus_reset_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (!bsy_o && !sel_o && !err_o && !disc_o));

  a_r2_arb_single_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_o && data_oe_o) |-> ($countones(data_o) == 1));

  a_r4_sel_after_arb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_o) |-> $past(bsy_o));

  a_r4_sel_two_ids: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> ($countones(data_o) == 2));

  a_r5_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(req_i));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !bsy_o && !sel_o));

  a_r9_disc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_o |-> (!sel_o && !bsy_o && !data_oe_o));

  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ack_o && !data_oe_o && !bsy_o && !sel_o));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !bus_rst_i) |=> err_o);
endmodule

bind scsi_phase_seq scsi_phase_seq_chk #(.BW(BW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_rst_i (bus_rst_i),
  .req_i     (req_i),
  .bsy_o     (bsy_o),
  .sel_o     (sel_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .ack_o     (ack_o),
  .done_o    (done_o),
  .disc_o    (disc_o),
  .err_o     (err_o)
);

// File: tb/scsi_phase_seq_test.sv
`timescale 1ns/1ps
module scsi_phase_seq_test;
  localparam logic [1:0] K_TX = 2'd0, K_RX = 2'd1, K_DONE = 2'd2, K_ERR = 2'd3;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] val;
  } ev_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rst_i = 1'b0, start_i = 1'b0;
  logic [2:0] tgt_id_i = '0;
  logic [4:0] cmd_len_i = '0;
  logic cbuf_we_i = 1'b0;
  logic [3:0] cbuf_addr_i = '0;
  logic [7:0] cbuf_data_i = '0;
  logic bus_bsy_i = 1'b0, bus_sel_i = 1'b0;
  logic [7:0] id_bus_i = '0;
  logic req_i = 1'b0;
  logic [2:0] phase_i = '0;
  logic [7:0] data_i = '0, dout_i = '0;
  logic tx_take_o, bsy_o, sel_o, data_oe_o, ack_o, rx_valid_o, done_o, disc_o, err_o;
  logic [7:0] data_o, rx_data_o, status_o;

  int checks = 0, failures = 0;
  ev_t exp_q[$];
  logic err_prev = 1'b0;

  always #2.5 clk = ~clk;

  scsi_phase_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst_i), .start_i(start_i),
    .tgt_id_i(tgt_id_i), .cmd_len_i(cmd_len_i), .cbuf_we_i(cbuf_we_i),
    .cbuf_addr_i(cbuf_addr_i), .cbuf_data_i(cbuf_data_i), .bus_bsy_i(bus_bsy_i),
    .bus_sel_i(bus_sel_i), .id_bus_i(id_bus_i), .req_i(req_i), .phase_i(phase_i),
    .data_i(data_i), .dout_i(dout_i), .tx_take_o(tx_take_o), .bsy_o(bsy_o),
    .sel_o(sel_o), .data_o(data_o), .data_oe_o(data_oe_o), .ack_o(ack_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .done_o(done_o),
    .status_o(status_o), .disc_o(disc_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic push(input logic [1:0] k, input logic [7:0] v);
    exp_q.push_back({k, v});
  endtask

  task automatic req(input logic [2:0] ph, input logic [7:0] b);
    phase_i = ph; data_i = b; req_i = 1'b1;
    tick();
    req_i = 1'b0;
  endtask

  task automatic start(input logic [2:0] t, input logic [4:0] n);
    tgt_id_i = t; cmd_len_i = n; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic wait_bsy();
    for (int n = 0; n < 50 && !bsy_o; n++) tick();
  endtask

  task automatic connect(input logic [2:0] t, input logic [4:0] n);
    id_bus_i = 8'h40;
    start(t, n);
    wait_bsy();
    tick();
    bus_bsy_i = 1'b1;
    tick();
  endtask

  task automatic bus_reset();
    bus_rst_i = 1'b1; tick(); bus_rst_i = 1'b0;
    bus_bsy_i = 1'b0; bus_sel_i = 1'b0; id_bus_i = '0;
    tick();
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_ni) begin
      ev_t got, want;
      logic have;
      string tag;
      for (int k = 0; k < 4; k++) begin
        have = 1'b0;
        case (k)
          0: if (ack_o && data_oe_o) begin have = 1'b1; got = {K_TX, data_o}; tag = "R5/R6 tx"; end
          1: if (rx_valid_o) begin have = 1'b1; got = {K_RX, rx_data_o}; tag = "R6 rx"; end
          2: if (done_o) begin have = 1'b1; got = {K_DONE, status_o}; tag = "R7 done"; end
          default: if (err_o && !err_prev) begin have = 1'b1; got = {K_ERR, 8'h00}; tag = "R10 err"; end
        endcase
        if (have) begin
          if (exp_q.size() == 0) chk(1'b0, {tag, " unexpected"}, 32'(got), 32'h3ff);
          else begin
            want = exp_q.pop_front();
            chk(got == want, tag, 32'(got), 32'(want));
          end
        end
      end
      err_prev <= err_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic saw_sel;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk(!bsy_o && !sel_o && !data_oe_o && !err_o && !disc_o, "R1 reset idle",
        {bsy_o, sel_o, data_oe_o, err_o, disc_o}, 0);

    begin
      logic [7:0] cb [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
      for (int i = 0; i < 4; i++) begin
        cbuf_we_i = 1'b1; cbuf_addr_i = 4'(i); cbuf_data_i = cb[i]; tick();
      end
      cbuf_we_i = 1'b0;
    end

    // normal command, lower-ID competitor present
    id_bus_i = 8'h60;
    start(3'd2, 5'd4);
    wait_bsy();
    chk(bsy_o && data_oe_o && data_o == 8'h40, "R2 arbitration drives own bit", data_o, 8'h40);
    tick();
    chk(sel_o && !bsy_o && data_o == 8'h44, "R3 R4 lower id ignored, select", {sel_o, bsy_o, data_o}, {2'b10, 8'h44});
    id_bus_i = '0; bus_bsy_i = 1'b1;
    tick();
    chk(!sel_o, "R4 sel released on target busy", sel_o, 0);
    push(K_TX, 8'hC0); req(3'd6, 8'h00);
    push(K_TX, 8'h12); req(3'd2, 8'h00);
    push(K_TX, 8'h34); req(3'd2, 8'h00);
    push(K_TX, 8'h56); req(3'd2, 8'h00);
    push(K_TX, 8'h78); req(3'd2, 8'h00);
    push(K_RX, 8'hA5); req(3'd1, 8'hA5);
    push(K_RX, 8'h5A); req(3'd1, 8'h5A);
    dout_i = 8'h3C;
    push(K_TX, 8'h3C); req(3'd0, 8'h00);
    req(3'd7, 8'h02);
    req(3'd7, 8'h03);
    req(3'd7, 8'h80);
    chk(!err_o, "R8 save/restore/identify accepted", err_o, 0);
    req(3'd3, 8'h02);
    push(K_DONE, 8'h02); req(3'd7, 8'h00);
    tick();
    chk(!bsy_o && !sel_o && !data_oe_o && !err_o, "R7 bus free after complete",
        {bsy_o, sel_o, data_oe_o, err_o}, 0);
    bus_bsy_i = 1'b0;

    // higher-ID competitor: must lose and retry
    id_bus_i = 8'hC0;
    start(3'd2, 5'd4);
    saw_sel = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(); saw_sel |= sel_o; end
    chk(!saw_sel, "R3 loser never selects", saw_sel, 0);
    id_bus_i = 8'h40;
    for (int i = 0; i < 20 && !sel_o; i++) tick();
    chk(sel_o, "R3 retry wins when free", sel_o, 1);
    bus_bsy_i = 1'b1; tick();
    push(K_TX, 8'h12); req(3'd2, 8'h00);
    push(K_TX, 8'h34); req(3'd2, 8'h00);
    push(K_TX, 8'h56); req(3'd2, 8'h00);
    push(K_TX, 8'h78); req(3'd2, 8'h00);
    push(K_RX, 8'h11); req(3'd1, 8'h11);
    req(3'd7, 8'h04);
    tick();
    chk(disc_o && !bsy_o, "R9 disconnect releases", {disc_o, bsy_o}, 2'b10);
    bus_bsy_i = 1'b0; id_bus_i = '0;
    start(3'd3, 5'd2);
    tick(); tick();
    chk(!bsy_o && disc_o, "R9 start ignored while disconnected", {bsy_o, disc_o}, 2'b01);
    bus_sel_i = 1'b1; id_bus_i = 8'h48;
    tick(); tick();
    chk(!bsy_o && disc_o, "R9 wrong target reselect ignored", {bsy_o, disc_o}, 2'b01);
    id_bus_i = 8'h44;
    tick();
    chk(bsy_o, "R9 reselect answered", bsy_o, 1);
    bus_sel_i = 1'b0; bus_bsy_i = 1'b1; id_bus_i = '0;
    tick();
    chk(!bsy_o && !disc_o, "R9 resumed", {bsy_o, disc_o}, 0);
    req(3'd3, 8'h00);
    push(K_DONE, 8'h00); req(3'd7, 8'h00);
    bus_bsy_i = 1'b0;
    repeat (4) tick();
    chk(!bsy_o && !err_o, "R9 no stale start after resume", {bsy_o, err_o}, 0);

    // complete without status
    connect(3'd2, 5'd1);
    push(K_TX, 8'h12); req(3'd2, 8'h00);
    push(K_ERR, 8'h00); req(3'd7, 8'h00);
    chk(err_o, "R7 complete without status errs", err_o, 1);
    req(3'd1, 8'h55);
    chk(!ack_o && !rx_valid_o, "R10 no ack in error", {ack_o, rx_valid_o}, 0);
    start(3'd2, 5'd1);
    tick(); tick();
    chk(err_o && !bsy_o, "R10 start ignored in error", {err_o, bsy_o}, 2'b10);
    bus_reset();
    chk(!err_o && !bsy_o && !sel_o, "R1 R10 bus reset clears", {err_o, bsy_o, sel_o}, 0);

    // extra command byte
    connect(3'd2, 5'd1);
    push(K_TX, 8'h12); req(3'd2, 8'h00);
    push(K_ERR, 8'h00); req(3'd2, 8'h00);
    chk(err_o, "R5 extra command byte errs", err_o, 1);
    bus_reset();

    // data before command finished
    connect(3'd2, 5'd2);
    push(K_TX, 8'h12); req(3'd2, 8'h00);
    push(K_ERR, 8'h00); req(3'd0, 8'h00);
    chk(err_o, "R6 data before command errs", err_o, 1);
    bus_reset();

    // reserved phase
    connect(3'd2, 5'd1);
    push(K_ERR, 8'h00); req(3'd5, 8'h00);
    chk(err_o, "R10 reserved phase errs", err_o, 1);
    bus_reset();

    // bad message
    connect(3'd2, 5'd1);
    push(K_ERR, 8'h00); req(3'd7, 8'h55);
    chk(err_o, "R8 unknown message errs", err_o, 1);
    bus_reset();

    // start naming own ID
    id_bus_i = 8'h40;
    start(3'd6, 5'd1);
    saw_sel = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); saw_sel |= bsy_o; end
    chk(!saw_sel, "R2 own-ID start ignored", saw_sel, 0);

    tick();
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule